// File: doc/BRIEF.md
# Adaptive Min/Non-Min Route Selector for a 2D Flattened Butterfly

This block computes the route of one flit per clock for a router in a two-dimensional flattened butterfly made of K x K routers. Each router has C local terminals. When a packet enters from a local terminal, the block weighs the minimal path against a detour through a randomly drawn intermediate terminal. The cost of each path is its hop count multiplied by the occupancy of the downstream queue it would use, and the detour pays a fixed bias. A packet that takes the detour is marked as heading to the intermediate. Once it reaches the intermediate's router it is marked as heading to its real destination.

The router supplies several things with each flit: the current router id, the input channel, the header fields (source, destination, phase, stored intermediate), the virtual-channel range of the packet's traffic class, and one occupancy count per output port. On the next clock the block returns the output port, the virtual-channel sub-range, and the phase and intermediate to write back into the header. It also returns an error flag for port indices beyond the router radix. The random intermediate comes from an internal 16-bit LFSR.

Top module: `ugal_route`

## Requirements
- R1: Every result is registered. `out_valid` is high exactly one cycle after `in_valid` was high, and low after an idle cycle. A synchronous active-high `rst` clears `out_valid`.
- R2: A flit whose `in_chan` is below C comes from a local terminal and is treated as phase 0 (decide) whatever `fl_phase` holds. On any other input the header phase is used (0 decide, 1 to intermediate, 2 to destination).
- R3: A router id r has coordinates x = r mod K and y = r / K, and terminal t sits on router t / C. Distance is the number of coordinates that differ (0, 1 or 2). Minimal hops are the distance from the source router to the destination router.
- R4: A phase-0 flit not yet at its destination router chooses the minimal path (output phase 2) when min_hops*min_queue <= alt_hops*alt_queue + 2. Otherwise it leaves with phase 1 and `out_intm` set to the drawn intermediate. Alt hops are source-to-intermediate plus intermediate-to-destination. Each queue value is the occupancy of the port toward that target, and a port index at or above the radix reads as 0.
- R5: When the drawn intermediate lies on the current router, the detour cost counts as infinite and the minimal path is always chosen.
- R6: In phase 1 the flit is routed toward `fl_intm`. If the intermediate's router is the current router, the phase becomes 2 and the flit is routed toward `fl_dst`. Without a detour decision, `out_intm` repeats `fl_intm`.
- R7: When the routing target's terminal is on the current router, the port is target mod C and the VC range is the full class range.
- R8: On a non-local port, half = (hi-lo+1)/2. Phase 1 gets VCs [lo, lo+half-1] and phase 2 gets [lo+half, hi].
- R9: Toward another router, the X dimension is corrected first. The X port is C + (tx < cx ? tx : tx-1), and otherwise the Y port is C + K-1 + (ty < cy ? ty : ty-1).
- R10: `out_err` is high when the computed port index is at or above the radix C + 2(K-1). This happens for destination ids beyond the network. `out_port` then holds no meaning.
- R11: The intermediate is the LFSR state mod (K*K*C). The LFSR is a right-shifting Galois register with mask 0xB400, loaded with 0xACE1 during reset, and it steps on every clock out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A flit is presented this cycle |
| in_chan | input | PW | Input channel index; below C means local terminal |
| cur_rtr | input | RW | Id of this router |
| fl_src | input | TW | Source terminal of the flit |
| fl_dst | input | TW | Destination terminal (out-of-range ids allowed) |
| fl_intm | input | TW | Intermediate terminal held in the header |
| fl_phase | input | 2 | Phase held in the header |
| cls_vc_lo | input | VCW | Lowest VC of the traffic class |
| cls_vc_hi | input | VCW | Highest VC of the traffic class (at least lo+1) |
| q_occ | input | RADIX*QW | Per-port queue occupancy, port p at bits [QW*p +: QW] |
| out_valid | output | 1 | Result valid |
| out_port | output | PW | Selected output port |
| out_vc_lo | output | VCW | Lowest allowed VC |
| out_vc_hi | output | VCW | Highest allowed VC |
| out_phase | output | 2 | Phase to write back |
| out_intm | output | TW | Intermediate to write back |
| out_err | output | 1 | Port index at or above the radix |

## Verification
Every field is due exactly one clock after its request is sampled, including the intermediate drawn from the LFSR state that is current at that clock. The bench drives each request just after a falling edge and computes the expected result from its own integer model and LFSR copy. It steps that copy once per rising edge out of reset and compares all fields at the next falling edge, one full cycle later. Idle cycles are compared too, so a stray or missing `out_valid` shows up in the cycle it occurs.

// File: rtl/ugal_pkg.sv
package ugal_pkg;
  typedef enum logic [1:0] {
    PH_DECIDE = 2'd0,
    PH_TO_MID = 2'd1,
    PH_TO_DST = 2'd2
  } phase_e;

  localparam int          LFSR_W    = 16;
  localparam logic [15:0] LFSR_MASK = 16'hB400;
  localparam logic [15:0] LFSR_INIT = 16'hACE1;
endpackage

// File: rtl/ugal_lfsr.sv
module ugal_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   MASK = 16'hB400,
  parameter logic [W-1:0]   INIT = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= INIT;
    else     state <= {1'b0, state[W-1:1]} ^ (state[0] ? MASK : '0);
  end
endmodule

// File: rtl/ugal_port_calc.sv
module ugal_port_calc #(
  parameter int K   = 4,
  parameter int C   = 2,
  parameter int TW  = 6,
  parameter int RW  = 4,
  parameter int OPW = 8
) (
  input  logic [TW-1:0]  tgt,
  input  logic [RW-1:0]  cur,
  output logic [OPW-1:0] port,
  output logic           here
);
  always_comb begin
    int tr, tx, ty, cx, cy, p;
    tr   = int'(tgt) / C;
    tx   = tr % K;
    ty   = tr / K;
    cx   = int'(cur) % K;
    cy   = int'(cur) / K;
    here = (tr == int'(cur));
    if (here)          p = int'(tgt) % C;
    else if (tx != cx) p = C + ((tx < cx) ? tx : tx - 1);
    else               p = C + (K - 1) + ((ty < cy) ? ty : ty - 1);
    port = OPW'(p);
  end
endmodule

// File: rtl/ugal_route.sv
module ugal_route
  import ugal_pkg::*;
#(
  parameter int K    = 4,
  parameter int C    = 2,
  parameter int QW   = 6,
  parameter int VCW  = 3,
  parameter int BIAS = 2,
  localparam int NROUT = K * K,
  localparam int NTERM = NROUT * C,
  localparam int RADIX = C + 2 * (K - 1),
  localparam int TW    = $clog2(NTERM) + 1,
  localparam int RW    = $clog2(NROUT),
  localparam int PW    = $clog2(RADIX),
  localparam int OPW   = TW + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [PW-1:0]         in_chan,
  input  logic [RW-1:0]         cur_rtr,
  input  logic [TW-1:0]         fl_src,
  input  logic [TW-1:0]         fl_dst,
  input  logic [TW-1:0]         fl_intm,
  input  logic [1:0]            fl_phase,
  input  logic [VCW-1:0]        cls_vc_lo,
  input  logic [VCW-1:0]        cls_vc_hi,
  input  logic [RADIX*QW-1:0]   q_occ,
  output logic                  out_valid,
  output logic [PW-1:0]         out_port,
  output logic [VCW-1:0]        out_vc_lo,
  output logic [VCW-1:0]        out_vc_hi,
  output logic [1:0]            out_phase,
  output logic [TW-1:0]         out_intm,
  output logic                  out_err
);
  localparam int SEL_DST = 0;
  localparam int SEL_MID = 1;
  localparam int SEL_RND = 2;
  localparam int NCALC   = 3;

  logic [LFSR_W-1:0] rng;
  logic [TW-1:0]     rnd_t;

  ugal_lfsr #(.W(LFSR_W), .MASK(LFSR_MASK), .INIT(LFSR_INIT)) u_rng (
    .clk(clk), .rst(rst), .state(rng)
  );

  assign rnd_t = TW'(int'(rng) % NTERM);

  logic [TW-1:0]  calc_tgt  [NCALC];
  logic [OPW-1:0] calc_port [NCALC];
  logic           calc_here [NCALC];

  assign calc_tgt[SEL_DST] = fl_dst;
  assign calc_tgt[SEL_MID] = fl_intm;
  assign calc_tgt[SEL_RND] = rnd_t;

  for (genvar g = 0; g < NCALC; g++) begin : g_calc
    ugal_port_calc #(.K(K), .C(C), .TW(TW), .RW(RW), .OPW(OPW)) u_pc (
      .tgt (calc_tgt[g]),
      .cur (cur_rtr),
      .port(calc_port[g]),
      .here(calc_here[g])
    );
  end

  function automatic int rdist(input int a, input int b);
    return (((a % K) != (b % K)) ? 1 : 0) + (((a / K) != (b / K)) ? 1 : 0);
  endfunction

  logic [1:0]     nx_phase;
  logic [TW-1:0]  nx_intm;
  logic [OPW-1:0] nx_port;
  logic [VCW-1:0] nx_lo, nx_hi;
  logic           nx_err;

  always_comb begin
    int src_r, dst_r, rnd_r, mq, nq, cost_min, cost_alt, sel, half;
    logic [1:0] ph;
    logic decide, take_min;

    ph     = (int'(in_chan) < C) ? PH_DECIDE : fl_phase;
    src_r  = int'(fl_src) / C;
    dst_r  = int'(fl_dst) / C;
    rnd_r  = int'(rnd_t) / C;
    mq     = (int'(calc_port[SEL_DST]) < RADIX) ?
             int'(q_occ[int'(calc_port[SEL_DST])*QW +: QW]) : 0;
    nq     = (int'(calc_port[SEL_RND]) < RADIX) ?
             int'(q_occ[int'(calc_port[SEL_RND])*QW +: QW]) : 0;
    cost_min = rdist(src_r, dst_r) * mq;
    cost_alt = (rdist(src_r, rnd_r) + rdist(rnd_r, dst_r)) * nq + BIAS;
    take_min = calc_here[SEL_RND] || (cost_min <= cost_alt);
    decide   = (ph == PH_DECIDE) && !calc_here[SEL_DST];

    nx_phase = ph;
    nx_intm  = fl_intm;
    sel      = SEL_DST;
    if (decide) begin
      if (take_min) begin
        nx_phase = PH_TO_DST;
      end else begin
        nx_phase = PH_TO_MID;
        nx_intm  = rnd_t;
        sel      = SEL_RND;
      end
    end else if (ph == PH_TO_MID) begin
      if (calc_here[SEL_MID]) nx_phase = PH_TO_DST;
      else                    sel      = SEL_MID;
    end

    nx_port = calc_port[sel];
    half    = (int'(cls_vc_hi) - int'(cls_vc_lo) + 1) / 2;
    nx_lo   = cls_vc_lo;
    nx_hi   = cls_vc_hi;
    if (int'(nx_port) >= C) begin
      if (nx_phase == PH_TO_MID) nx_hi = VCW'(int'(cls_vc_lo) + half - 1);
      else                       nx_lo = VCW'(int'(cls_vc_lo) + half);
    end
    nx_err = (int'(nx_port) >= RADIX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_vc_lo <= '0;
      out_vc_hi <= '0;
      out_phase <= '0;
      out_intm  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port  <= nx_port[PW-1:0];
        out_vc_lo <= nx_lo;
        out_vc_hi <= nx_hi;
        out_phase <= nx_phase;
        out_intm  <= nx_intm;
        out_err   <= nx_err;
      end
    end
  end
endmodule

// File: rtl/ugal_route_chk.sv
module ugal_route_chk #(
  parameter int K   = 4,
  parameter int C   = 2,
  parameter int QW  = 6,
  parameter int VCW = 3,
  localparam int NROUT = K * K,
  localparam int NTERM = NROUT * C,
  localparam int RADIX = C + 2 * (K - 1),
  localparam int TW    = $clog2(NTERM) + 1,
  localparam int PW    = $clog2(RADIX)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [VCW-1:0] cls_vc_lo,
  input logic [VCW-1:0] cls_vc_hi,
  input logic           out_valid,
  input logic [PW-1:0]  out_port,
  input logic [VCW-1:0] out_vc_lo,
  input logic [VCW-1:0] out_vc_hi,
  input logic [1:0]     out_phase,
  input logic           out_err
);
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R1
  AST_EJECT_FULL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && int'(out_port) < C) |->
      (out_vc_lo == $past(cls_vc_lo) && out_vc_hi == $past(cls_vc_hi)));  // R7
  AST_ROUTED_PHASE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && int'(out_port) >= C) |->
      (out_phase == 2'd1 || out_phase == 2'd2));  // R4
  AST_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && int'(out_port) >= C && out_phase == 2'd1) |->
      (out_vc_lo == $past(cls_vc_lo) && out_vc_hi < $past(cls_vc_hi)));  // R8
  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && int'(out_port) >= C && out_phase == 2'd2) |->
      (out_vc_hi == $past(cls_vc_hi) && out_vc_lo > $past(cls_vc_lo)));  // R8
  AST_PORT_IN_RADIX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> (int'(out_port) < RADIX));  // R10
endmodule

bind ugal_route ugal_route_chk #(.K(K), .C(C), .QW(QW), .VCW(VCW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .cls_vc_lo(cls_vc_lo), .cls_vc_hi(cls_vc_hi),
  .out_valid(out_valid), .out_port(out_port),
  .out_vc_lo(out_vc_lo), .out_vc_hi(out_vc_hi),
  .out_phase(out_phase), .out_err(out_err)
);

// File: tb/ugal_route_test.sv
module ugal_route_test;
  localparam int PERIOD = 10;
  localparam int K = 4, C = 2, QW = 6, VCW = 3;
  localparam int NTERM = K * K * C, RADIX = C + 2 * (K - 1);
  localparam int TW = 6, RW = 4, PW = 3;

  logic clk = 0, rst = 1;
  logic in_valid = 0;
  logic [PW-1:0] in_chan = 0;
  logic [RW-1:0] cur_rtr = 0;
  logic [TW-1:0] fl_src = 0, fl_dst = 0, fl_intm = 0;
  logic [1:0] fl_phase = 0;
  logic [VCW-1:0] cls_vc_lo = 0, cls_vc_hi = 1;
  logic [RADIX*QW-1:0] q_occ = '0;
  logic out_valid, out_err;
  logic [PW-1:0] out_port;
  logic [VCW-1:0] out_vc_lo, out_vc_hi;
  logic [1:0] out_phase;
  logic [TW-1:0] out_intm;

  ugal_route #(.K(K), .C(C), .QW(QW), .VCW(VCW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int m_lfsr;
  int qv [RADIX];
  int e_valid, e_port, e_lo, e_hi, e_ph, e_intm, e_err;
  string t_port, t_vc, t_ph, t_intm;

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pcalc(int t, int cur);
    int tr = t / C, tx, ty, cx = cur % K, cy = cur / K;
    tx = tr % K; ty = tr / K;
    if (tr == cur) return t % C;
    if (tx != cx) return C + ((tx < cx) ? tx : tx - 1);
    return C + K - 1 + ((ty < cy) ? ty : ty - 1);
  endfunction

  function automatic int hops(int a, int b);
    return ((a % K != b % K) ? 1 : 0) + ((a / K != b / K) ? 1 : 0);
  endfunction

  function automatic int qval(int p);
    return (p < RADIX) ? qv[p] : 0;
  endfunction

  task automatic predict();
    int ph, cur, tgt, rnd, p, half, mq, nq, sr, dr, rr;
    bit take;
    cur = cur_rtr;
    ph = (in_chan < C) ? 0 : fl_phase;
    tgt = fl_dst; e_ph = ph; e_intm = fl_intm;
    rnd = m_lfsr % NTERM;
    t_ph = "R6"; t_intm = "R6";
    if (ph == 0 && fl_dst / C != cur) begin
      sr = fl_src / C; dr = fl_dst / C; rr = rnd / C;
      mq = qval(pcalc(fl_dst, cur));
      if (rr == cur) begin
        take = 1; t_ph = "R5";
      end else begin
        nq = qval(pcalc(rnd, cur));
        take = hops(sr, dr) * mq <= (hops(sr, rr) + hops(rr, dr)) * nq + 2;
        t_ph = take ? "R3" : "R4";
      end
      if (in_chan < C && fl_phase != 0) t_ph = "R2";
      if (take) e_ph = 2;
      else begin e_ph = 1; tgt = rnd; e_intm = rnd; t_intm = "R11"; end
    end else if (ph == 1) begin
      if (fl_intm / C == cur) e_ph = 2; else tgt = fl_intm;
    end
    p = pcalc(tgt, cur);
    e_err = (p >= RADIX) ? 1 : 0;
    e_port = p % 8;
    e_lo = cls_vc_lo; e_hi = cls_vc_hi;
    t_port = (p < C) ? "R7" : "R9"; t_vc = (p < C) ? "R7" : "R8";
    if (p >= C) begin
      half = (cls_vc_hi - cls_vc_lo + 1) / 2;
      if (e_ph == 1) e_hi = cls_vc_lo + half - 1; else e_lo = cls_vc_lo + half;
    end
  endtask

  task automatic compare();
    chk("R1", "valid", out_valid, e_valid);
    if (e_valid && out_valid) begin
      chk("R10", "err", out_err, e_err);
      if (!e_err) chk(t_port, "port", out_port, e_port);
      chk(t_vc, "vc_lo", out_vc_lo, e_lo);
      chk(t_vc, "vc_hi", out_vc_hi, e_hi);
      chk(t_ph, "phase", out_phase, e_ph);
      chk(t_intm, "intm", out_intm, e_intm);
    end
  endtask

  function automatic int lstep(int s);
    int n = s >> 1;
    if (s & 1) n = n ^ 'hB400;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int mode, qm, lo;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", out_valid, 0);
    rst = 0;
    m_lfsr = 'hACE1;
    e_valid = 0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      compare();
      m_lfsr = lstep(m_lfsr);
      in_valid = (($urandom % 8) != 0);
      cur_rtr  = RW'($urandom % 16);
      mode     = $urandom % 8;
      if (mode == 0)      fl_dst = TW'(cur_rtr * C + $urandom % C);
      else if (mode == 1) fl_dst = TW'(32 + $urandom % 32);
      else                fl_dst = TW'($urandom % NTERM);
      fl_src   = TW'($urandom % NTERM);
      in_chan  = ($urandom % 2) ? PW'($urandom % C) : PW'($urandom % 8);
      fl_phase = 2'($urandom % 3);
      fl_intm  = (mode == 2) ? TW'(cur_rtr * C + $urandom % C) : TW'($urandom % NTERM);
      lo = $urandom % 4;
      cls_vc_lo = VCW'(lo);
      cls_vc_hi = VCW'(lo + 1 + $urandom % (7 - lo));
      qm = $urandom % 4;
      for (int p = 0; p < RADIX; p++) begin
        qv[p] = (qm == 0) ? 0 : (qm == 1) ? 63 : (qm == 2) ? ($urandom % 4) * 21 : $urandom % 64;
        q_occ[p*QW +: QW] = QW'(qv[p]);
      end
      predict();
      e_valid = in_valid;
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule